// File: doc/BRIEF.md
# Real-Time Match Counter

This block is an up-counter that is advanced by a slow external reference, typically a 32.768 kHz crystal signal, instead of by the system clock. The reference is first brought into the system clock domain through a chain of flip-flops. Each rising edge is then reduced to a single-cycle tick. A tick advances the count by one, but only when three conditions hold: the timer enable is high, the real-time enable is high, and the configuration code selects real-time operation.

The count is compared with a programmable match value. A tick that arrives while the count equals that value sends the count back to zero instead of advancing it, and counting carries on. The same wrap sets a sticky match status bit. That bit raises the interrupt output whenever the interrupt mask bit is set. Software clears the status by pulsing a write-one-to-clear strobe. The match value is meant to be written while the timer is disabled, before the timer is enabled.

Top module: `rtcMatchTimer`

## Requirements
- R1: After reset the count is zero, the match status is low and the interrupt output is low.
- R2: With the block active, each rising edge of `refClkIn` raises the count by exactly one. A level held high or low, or a falling edge, leaves the count unchanged.
- R3: A rising edge of the reference that arrives while the count equals `matchVal` sets the count to zero and sets the match status. This applies for every match value, including zero.
- R4: After a wrap, counting continues from zero without software action, so the count repeats with a period of `matchVal`+1 reference edges.
- R5: While `timerEn` is low, reference edges leave the count unchanged.
- R6: While `rtcEn` is low, reference edges leave the count unchanged, even with `timerEn` high.
- R7: The block counts only when `cfgMode` is 3'b001. Any other code leaves the count unchanged.
- R8: The match status stays set until a cycle with `clrStatus` high clears it. If a match and a clear happen in the same cycle, the status is set.
- R9: `irq` is high exactly when the match status is set and `intMask` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMode | input | 3 | Configuration code; 3'b001 selects real-time counting |
| timerEn | input | 1 | Timer enable |
| rtcEn | input | 1 | Real-time counting enable |
| matchVal | input | CNT_W | Value at which the count wraps to zero |
| intMask | input | 1 | Interrupt mask; 1 lets the status drive `irq` |
| clrStatus | input | 1 | Write-one-to-clear strobe for the match status |
| refClkIn | input | 1 | Asynchronous slow reference input |
| count | output | CNT_W | Current count |
| matchStatus | output | 1 | Sticky match status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- `refClkIn` holds each level for at least two system cycles.
- `matchVal`, `cfgMode` and the enables change only while the block is not counting.
- The count was zero or at or below `matchVal` when the block was enabled. Without this, the count would run up to the top of its range before wrapping.

The stimulus keeps to all three. The reference stays at each level for four system cycles. The match value is changed only while `timerEn` is low and after a reset, and the enables are switched only between pulses. The sweep uses a 4-bit counter and covers all sixteen match values over more than two full periods.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam logic [2:0] MODE_RTC = 3'b001;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic statSet;
    logic statClr;
  } rtcStrobe_t;
endpackage

// File: rtl/rtcSync.sv
module rtcSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rtcCtl.sv
module rtcCtl
  import rtcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refSync,
  input  logic [2:0] cfgMode,
  input  logic       timerEn,
  input  logic       rtcEn,
  input  logic       atMatch,
  input  logic       clrStatus,
  output rtcStrobe_t strobe
);
  logic prevLvl;
  logic tick;
  logic active;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= refSync;

  assign tick   = refSync & ~prevLvl;
  assign active = timerEn & rtcEn & (cfgMode == MODE_RTC);

  always_comb begin
    strobe.cntInc  = tick & active & ~atMatch;
    strobe.cntClr  = tick & active & atMatch;
    strobe.statSet = tick & active & atMatch;
    strobe.statClr = clrStatus;
  end
endmodule

// File: rtl/rtcDp.sv
module rtcDp
  import rtcPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  rtcStrobe_t       strobe,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             intMask,
  output logic [CNT_W-1:0] count,
  output logic             atMatch,
  output logic             matchStatus,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              count <= '0;
    else if (strobe.cntClr) count <= '0;
    else if (strobe.cntInc) count <= count + ONE;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               matchStatus <= 1'b0;
    else if (strobe.statSet) matchStatus <= 1'b1;
    else if (strobe.statClr) matchStatus <= 1'b0;

  assign atMatch = (count == matchVal);
  assign irq     = matchStatus & intMask;
endmodule

// File: rtl/rtcMatchTimer.sv
module rtcMatchTimer
  import rtcPkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cfgMode,
  input  logic             timerEn,
  input  logic             rtcEn,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             intMask,
  input  logic             clrStatus,
  input  logic             refClkIn,
  output logic [CNT_W-1:0] count,
  output logic             matchStatus,
  output logic             irq
);
  logic       refSync;
  logic       atMatch;
  rtcStrobe_t strobe;

  rtcSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(refClkIn), .syncOut(refSync)
  );

  rtcCtl uCtl (
    .clk(clk), .rstN(rstN), .refSync(refSync), .cfgMode(cfgMode),
    .timerEn(timerEn), .rtcEn(rtcEn), .atMatch(atMatch),
    .clrStatus(clrStatus), .strobe(strobe)
  );

  rtcDp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchVal(matchVal),
    .intMask(intMask), .count(count), .atMatch(atMatch),
    .matchStatus(matchStatus), .irq(irq)
  );
endmodule

// File: rtl/rtcMatchChk.sv
module rtcMatchChk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cfgMode,
  input logic             timerEn,
  input logic             rtcEn,
  input logic [CNT_W-1:0] matchVal,
  input logic             intMask,
  input logic             clrStatus,
  input logic             refClkIn,
  input logic [CNT_W-1:0] count,
  input logic             matchStatus,
  input logic             irq
);
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1) || count == '0)); // R2

  AST_WRAP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == $past(matchVal) && count != $past(count)) |-> (count == '0 && matchStatus)); // R3

  AST_HOLD_TIMER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !$past(timerEn) |-> $stable(count)); // R5

  AST_HOLD_RTC_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rtcEn) |-> $stable(count)); // R6

  AST_HOLD_OTHER_MODE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgMode) != 3'b001) |-> $stable(count)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(matchStatus) && !$past(clrStatus)) |-> matchStatus); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (matchStatus && intMask)); // R9

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (matchStatus && intMask) |-> irq); // R9
endmodule

bind rtcMatchTimer rtcMatchChk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/tb_rtcMatchTimer.sv
module tb_rtcMatchTimer;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   cfgMode = 3'b001;
  logic         timerEn = 1'b0;
  logic         rtcEn = 1'b1;
  logic [W-1:0] matchVal = '0;
  logic         intMask = 1'b0;
  logic         clrStatus = 1'b0;
  logic         refClkIn = 1'b0;
  logic [W-1:0] count;
  logic         matchStatus;
  logic         irq;

  int tests = 0;
  int fails = 0;
  int expCnt;
  bit expStat;

  always #2 clk = ~clk;

  rtcMatchTimer #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .timerEn(timerEn),
    .rtcEn(rtcEn), .matchVal(matchVal), .intMask(intMask),
    .clrStatus(clrStatus), .refClkIn(refClkIn), .count(count),
    .matchStatus(matchStatus), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseRef();
    @(negedge clk);
    refClkIn = 1'b1;
    repeat (4) @(negedge clk);
    refClkIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clearPulse();
    @(negedge clk);
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    check("R1 count", int'(count), 0);
    check("R1 status", int'(matchStatus), 0);
    check("R1 irq", int'(irq), 0);

    // R2 R3 R4: sweep every match value over more than two periods
    for (int m = 0; m < (1 << W); m++) begin
      timerEn = 1'b0;
      intMask = 1'b0;
      doReset();
      matchVal = W'(m);
      timerEn = 1'b1;
      expCnt = 0;
      expStat = 1'b0;
      for (int p = 0; p < 2 * (m + 1) + 1; p++) begin
        pulseRef();
        if (expCnt == m) begin expCnt = 0; expStat = 1'b1; end
        else expCnt++;
        check(p > m ? "R4 count" : "R2/R3 count", int'(count), expCnt);
        check("R3 status", int'(matchStatus), int'(expStat));
      end
      check("R9 masked irq", int'(irq), 0);
      intMask = 1'b1;
      @(negedge clk);
      check("R9 irq", int'(irq), int'(expStat));
    end

    // R8: status sticky, then cleared
    repeat (5) @(negedge clk);
    check("R8 sticky", int'(matchStatus), 1);
    clearPulse();
    check("R8 cleared", int'(matchStatus), 0);
    check("R9 irq after clear", int'(irq), 0);

    // R2: steady high level does not count
    timerEn = 1'b0;
    doReset();
    matchVal = W'(9);
    timerEn = 1'b1;
    pulseRef();
    @(negedge clk);
    refClkIn = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 held high", int'(count), 2);
    refClkIn = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 falling edge", int'(count), 2);

    // R5
    timerEn = 1'b0;
    pulseRef(); pulseRef();
    check("R5 timer off", int'(count), 2);
    // R6
    timerEn = 1'b1;
    rtcEn = 1'b0;
    pulseRef(); pulseRef();
    check("R6 rtc off", int'(count), 2);
    // R7
    rtcEn = 1'b1;
    cfgMode = 3'b100;
    pulseRef();
    check("R7 mode 4", int'(count), 2);
    cfgMode = 3'b000;
    pulseRef();
    check("R7 mode 0", int'(count), 2);
    cfgMode = 3'b001;
    pulseRef();
    check("R7 mode 1 resumes", int'(count), 3);

    // R8: match and clear in the same cycle, set wins
    timerEn = 1'b0;
    doReset();
    matchVal = W'(0);
    timerEn = 1'b1;
    pulseRef();
    check("R8 first wrap", int'(matchStatus), 1);
    clearPulse();
    check("R8 clear ok", int'(matchStatus), 0);
    @(negedge clk);
    refClkIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clrStatus = 1'b1;
    @(negedge clk);
    clrStatus = 1'b0;
    check("R8 set beats clear", int'(matchStatus), 1);
    check("R3 count at zero", int'(count), 0);
    refClkIn = 1'b0;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule